// File: doc/BRIEF.md
# Burst-Capable PWM Channel

This block drives one pulse-width modulated output. Its behaviour is set by a 32-bit control word. The word holds a clock prescaler, the level treated as active, a mode bit, a start bit and a burst count. A separate period interface loads two values. The first is the number of counter steps in a full period, called the frame length. The second is the number of steps at the start of each period during which the output is active, called the high count. Both values go into shadow registers. They reach the working registers only at the end of a period, so a period that has already started is never cut short or distorted. A status bit in the control word stays set while such an update is waiting.

There are two ways to run the channel. In continuous mode the waveform repeats for as long as the channel is enabled. In burst mode the channel stays idle until a start command arrives. It then emits a set number of complete periods, stops at the inactive level, and clears its start bit by itself. Software can therefore poll the start bit to see whether a burst is still running.

Top module: `pwm_burst_channel`

## Requirements
- R1: After reset the control word reads 0 and the output is at the inactive level. With polarity 0 the inactive level is high.
- R2: Control bits 7:0 hold K. The period counter steps once every K+1 clock cycles, and one period lasts (T+1)*(K+1) clocks, where T is the frame length.
- R3: Control bit 8 selects the active level: 1 means active-high and 0 means active-low. The inactive level is the opposite value.
- R4: The output is active while the period counter is below the high count D. When D is 0 the output stays inactive. When D is greater than T the output stays active.
- R5: With control bit 9 at 0 (continuous mode) and the channel enabled, periods repeat without a gap.
- R6: A control write with bit 9 at 1 and bit 10 at 1 starts a burst of N+1 periods, where N is held in bits 31:16. Bit 10 reads 1 for exactly (N+1)*(T+1)*(K+1) clocks. After that the output is inactive.
- R7: A start write is ignored while a burst is running, and it is also ignored in continuous mode. Writing 0 to bit 10 does not stop a burst that is running.
- R8: A period write sets bit 11 in the cycle after the write. While the channel is running, bit 11 clears at the next period end. The new frame length and high count take effect from the period that begins at that point.
- R9: Switching bit 9 to 0 during a burst ends the burst at the next period end. Output then continues in continuous mode.
- R10: When the enable input is low, the output is inactive, the counters are held at zero, any burst is cancelled and start writes are ignored.
- R11: When the channel is idle, a pending period update is copied in one cycle, so bit 11 reads 1 for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control word write data |
| ctrl_rdata_o | output | 32 | Control word readback, including the burst bit (10) and the busy bit (11) |
| per_we_i | input | 1 | Period write strobe |
| per_total_i | input | CNT_W | Frame length T; a period has T+1 steps |
| per_active_i | input | CNT_W | High count D |
| pwm_o | output | 1 | PWM output |

## Verification
A wrong prescaler or counter state changes the number of active clocks within the first period, which is at most (T+1)*(K+1) cycles, so it shows up in every measured window. Errors in the burst sequencer show at the readback bit 10. Such an error stretches or shortens a burst by whole periods, which makes the burst length differ from (N+1)*(T+1)*(K+1). A stuck shadow register shows up in two ways within one period of the busy bit clearing: the busy bit fails to clear, or the old high count is still in use.

// File: rtl/pwm_burst_pkg.sv
package pwm_burst_pkg;
  localparam int PRE_W   = 8;
  localparam int NUM_W   = 16;
  localparam int POL_BIT = 8;
  localparam int MODE_BIT  = 9;
  localparam int START_BIT = 10;
  localparam int BUSY_BIT  = 11;
  localparam int NUM_LSB   = 16;

  typedef enum logic {MODE_CONT = 1'b0, MODE_BURST = 1'b1} pwm_mode_e;

  typedef struct packed {
    logic [NUM_W-1:0] num;
    pwm_mode_e        mode;
    logic             pol;
    logic [PRE_W-1:0] k;
  } pwm_ctrl_t;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          clr_i,
  input  logic [PW-1:0] k_i,
  output logic          tick_o
);
  logic [PW-1:0] div_q;

  assign tick_o = run_i && (div_q == k_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else if (!run_i || clr_i || tick_o) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end

  // R2: consecutive steps are K+1 clocks apart
  assert_tick_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && (k_i != '0) |=> !tick_o || (k_i == '0));
endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic          per_we_i,
  input  logic [CW-1:0] total_i,
  input  logic [CW-1:0] active_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] duty_o,
  output logic          wrap_o,
  output logic          busy_o
);
  logic [CW-1:0] cnt_q, tot_q, duty_q, tot_sh_q, duty_sh_q;
  logic          busy_q, load;

  assign wrap_o = run_i && tick_i && (cnt_q == tot_q);
  assign load   = !run_i || clr_i || wrap_o;
  assign cnt_o  = cnt_q;
  assign duty_o = duty_q;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      tot_q     <= '0;
      duty_q    <= '0;
      tot_sh_q  <= '0;
      duty_sh_q <= '0;
      busy_q    <= 1'b0;
    end else begin
      if (load) cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
      if (per_we_i) begin
        tot_sh_q  <= total_i;
        duty_sh_q <= active_i;
        busy_q    <= 1'b1;
      end else if (load) begin
        busy_q <= 1'b0;
      end
      if (load && busy_q) begin
        tot_q  <= tot_sh_q;
        duty_q <= duty_sh_q;
      end
    end
  end

  assert_cnt_in_frame_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= tot_q);
  assert_busy_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_we_i |=> busy_o);
endmodule

// File: rtl/pwm_burst_seq.sv
module pwm_burst_seq
  import pwm_burst_pkg::*;
#(
  parameter int NW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  pwm_mode_e     mode_i,
  input  logic          start_i,
  input  logic [NW-1:0] num_i,
  input  logic          wrap_i,
  output logic          active_o
);
  logic          burst_q;
  logic [NW-1:0] idx_q;

  assign active_o = burst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      burst_q <= 1'b0;
      idx_q   <= '0;
    end else if (!en_i) begin
      burst_q <= 1'b0;
      idx_q   <= '0;
    end else if (start_i) begin
      burst_q <= 1'b1;
      idx_q   <= '0;
    end else if (burst_q && wrap_i) begin
      if (mode_i == MODE_CONT || idx_q >= num_i) begin
        burst_q <= 1'b0;
        idx_q   <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assert_start_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(start_i));
  assert_burst_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && wrap_i && (idx_q >= num_i) |=> !active_o);
  assert_disable_cancel_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !active_o);
endmodule

// File: rtl/pwm_burst_channel.sv
module pwm_burst_channel
  import pwm_burst_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ctrl_we_i,
  input  logic [31:0]      ctrl_wdata_i,
  output logic [31:0]      ctrl_rdata_o,
  input  logic             per_we_i,
  input  logic [CNT_W-1:0] per_total_i,
  input  logic [CNT_W-1:0] per_active_i,
  output logic             pwm_o
);
  pwm_ctrl_t        ctrl_q;
  logic             burst, busy, tick, wrap, run, start_go;
  logic [CNT_W-1:0] cnt, duty;
  logic             unused_wdata;

  assign unused_wdata = ^ctrl_wdata_i[15:11];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_we_i) begin
      ctrl_q.k    <= ctrl_wdata_i[PRE_W-1:0];
      ctrl_q.pol  <= ctrl_wdata_i[POL_BIT];
      ctrl_q.mode <= pwm_mode_e'(ctrl_wdata_i[MODE_BIT]);
      ctrl_q.num  <= ctrl_wdata_i[NUM_LSB +: NUM_W];
    end
  end

  // start accepted only in burst mode, enabled and idle
  assign start_go = ctrl_we_i && ctrl_wdata_i[START_BIT] && ctrl_wdata_i[MODE_BIT]
                    && en_i && !burst;
  assign run = en_i && (ctrl_q.mode == MODE_CONT || burst);

  pwm_prescaler #(.PW(PRE_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .clr_i(start_go),
    .k_i(ctrl_q.k), .tick_o(tick));

  pwm_period_counter #(.CW(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .clr_i(start_go), .tick_i(tick),
    .per_we_i(per_we_i), .total_i(per_total_i), .active_i(per_active_i),
    .cnt_o(cnt), .duty_o(duty), .wrap_o(wrap), .busy_o(busy));

  pwm_burst_seq #(.NW(NUM_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mode_i(ctrl_q.mode),
    .start_i(start_go), .num_i(ctrl_q.num), .wrap_i(wrap), .active_o(burst));

  assign pwm_o = (run && cnt < duty) ? ctrl_q.pol : ~ctrl_q.pol;

  assign ctrl_rdata_o = {ctrl_q.num, 4'b0000, busy, burst, ctrl_q.mode,
                         ctrl_q.pol, ctrl_q.k};

  assert_zero_duty_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty == '0) |-> (pwm_o == ~ctrl_q.pol));
  assert_disabled_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (pwm_o == ~ctrl_q.pol));
endmodule

// File: tb/pwm_burst_channel_tb.sv
module pwm_burst_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic          clk_i = 1'b0, rst_ni = 1'b0, en_i = 1'b0;
  logic          ctrl_we_i = 1'b0, per_we_i = 1'b0;
  logic [31:0]   ctrl_wdata_i = '0, ctrl_rdata_o;
  logic [CW-1:0] per_total_i = '0, per_active_i = '0;
  logic          pwm_o;
  int checks = 0, fails = 0;
  logic cur_pol = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pwm_burst_channel #(.CNT_W(CW)) u_dut (.*);

  function automatic logic [31:0] mk(int n, bit start, bit mode, bit pol, int k);
    return {n[15:0], 4'b0, 1'b0, start, mode, pol, k[7:0]};
  endfunction
  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction
  function automatic int exp_len(int n, int t, int k);
    return (n + 1) * (t + 1) * (k + 1);
  endfunction
  function automatic int exp_act(int n, int t, int d, int k);
    return (n + 1) * imin(d, t + 1) * (k + 1);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(logic [31:0] w);
    ctrl_we_i = 1'b1; ctrl_wdata_i = w; cur_pol = w[8];
    @(negedge clk_i);
    ctrl_we_i = 1'b0;
  endtask
  task automatic wr_per(int t, int d);
    per_we_i = 1'b1; per_total_i = t[CW-1:0]; per_active_i = d[CW-1:0];
    @(negedge clk_i);
    per_we_i = 1'b0;
  endtask

  // cycle-mode window of two periods from a fresh enable
  task automatic cont_window(int k, int t, int d, bit pol, string req);
    int act = 0;
    en_i = 1'b0;
    wr_per(t, d);
    wr_ctrl(mk(0, 0, 0, pol, k));
    repeat (2) @(negedge clk_i);
    en_i = 1'b1;
    for (int i = 0; i < 2 * (t + 1) * (k + 1); i++) begin
      #1;
      if (pwm_o == pol) act++;
      @(negedge clk_i);
    end
    chk(req, act, exp_act(1, t, d, k));
  endtask

  task automatic run_burst(int inj_at, logic [31:0] inj, output int len, output int act);
    len = 0; act = 0;
    while (ctrl_rdata_o[10] && len < 5000) begin
      if (pwm_o == cur_pol) act++;
      len++;
      if (len == inj_at) begin ctrl_we_i = 1'b1; ctrl_wdata_i = inj; end
      else ctrl_we_i = 1'b0;
      @(negedge clk_i);
    end
    ctrl_we_i = 1'b0;
  endtask

  task automatic setup_burst(int n, int t, int d, bit pol, int k);
    wr_ctrl(mk(n, 0, 1, pol, k));
    wr_per(t, d);
    repeat (2) @(negedge clk_i);
    wr_ctrl(mk(n, 1, 1, pol, k));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int len, act, w;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 ctrl reset", int'(ctrl_rdata_o), 0);
    chk("R1 idle level", int'(pwm_o), 1);

    // R11: idle copy, busy for one cycle
    wr_per(7, 3);
    chk("R11 busy set", int'(ctrl_rdata_o[11]), 1);
    @(negedge clk_i);
    chk("R11 busy clear", int'(ctrl_rdata_o[11]), 0);

    // R10: disabled is inactive with pol=1
    wr_ctrl(mk(0, 0, 0, 1, 0));
    #1 chk("R10 disabled inactive", int'(pwm_o), 0);
    @(negedge clk_i);

    // R2 R3 R4 R5 continuous windows
    cont_window(0, 7, 3, 1, "R5 cont k0");
    cont_window(2, 4, 2, 0, "R2 prescale k2 R3 low");
    cont_window(1, 3, 0, 1, "R4 duty zero");
    cont_window(0, 3, 9, 1, "R4 duty over frame");
    en_i = 1'b0;
    #1 chk("R10 disable drops", int'(pwm_o), 0);
    @(negedge clk_i);

    // R8: update while running
    en_i = 1'b1;
    wr_per(9, 2);
    wr_ctrl(mk(0, 0, 0, 1, 0));
    repeat (3) @(negedge clk_i);
    wr_per(5, 4);
    chk("R8 busy set running", int'(ctrl_rdata_o[11]), 1);
    w = 0;
    while (ctrl_rdata_o[11] && w < 40) begin w++; @(negedge clk_i); end
    chk("R8 busy clears within period", int'(w <= 10 && w >= 1), 1);
    act = 0;
    for (int i = 0; i < 6; i++) begin
      if (pwm_o == 1'b1) act++;
      @(negedge clk_i);
    end
    chk("R8 new duty after boundary", act, 4);

    // R7: start ignored in continuous mode
    wr_ctrl(mk(2, 1, 0, 1, 0));
    chk("R7 start in cont ignored", int'(ctrl_rdata_o[10]), 0);

    // R10: start while disabled ignored
    en_i = 1'b0;
    wr_ctrl(mk(2, 1, 1, 1, 0));
    chk("R10 start disabled ignored", int'(ctrl_rdata_o[10]), 0);
    en_i = 1'b1;

    // R6 directed burst
    setup_burst(2, 3, 1, 1, 1);
    run_burst(0, '0, len, act);
    chk("R6 burst length", len, exp_len(2, 3, 1));
    chk("R6 burst active clocks", act, exp_act(2, 3, 1, 1));
    #1 chk("R6 idle after burst", int'(pwm_o), 0);
    @(negedge clk_i);

    // R7: restart and clear-start during burst ignored
    setup_burst(1, 3, 2, 0, 0);
    run_burst(2, mk(1, 1, 1, 0, 0), len, act);
    chk("R7 restart ignored", len, exp_len(1, 3, 0));
    setup_burst(1, 3, 2, 0, 0);
    run_burst(3, mk(1, 0, 1, 0, 0), len, act);
    chk("R7 zero start no effect", len, exp_len(1, 3, 0));

    // R9: mode change aborts at boundary, then continuous
    setup_burst(5, 3, 2, 1, 1);
    run_burst(3, mk(5, 0, 0, 1, 1), len, act);
    chk("R9 abort at boundary", len, 8);
    act = 0;
    for (int i = 0; i < 8; i++) begin
      if (pwm_o == 1'b1) act++;
      @(negedge clk_i);
    end
    chk("R9 continues in cont mode", act, 4);

    // random bursts
    for (int it = 0; it < 24; it++) begin
      int k = $urandom % 4, t = 1 + $urandom % 7, d = $urandom % 10;
      int n = $urandom % 4;
      bit p = 1'($urandom % 2);
      setup_burst(n, t, d, p, k);
      run_burst(0, '0, len, act);
      chk("R6 random length", len, exp_len(n, t, k));
      chk("R4 random active", act, exp_act(n, t, d, k));
      #1 chk("R3 random idle level", int'(pwm_o), int'(!p));
      @(negedge clk_i);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule